// File: doc/BRIEF.md
# Bit-level I2C assist engine

This block helps a microcontroller run an I2C bus one bit at a time. Software keeps the byte-level work (shifting bits in and out, address matching, acknowledge handling, and producing START and STOP as a master). The hardware does the timing-critical parts that software cannot do reliably.

The hardware filters both bus lines and recognises START and STOP. It keeps a bus-busy flag and samples SDA on every SCL rising edge. After each SCL falling edge it holds SCL low, so the next bit waits until software says to go on. On each transmitted bit it checks for arbitration loss. It raises an interrupt on the first clock fall after a START. In master mode, writing the one-bit transmit register makes the block emit exactly one SCL pulse by itself.

The pins are modelled as open-drain. For each line the block reports the level it reads and whether it is pulling that line low. Software sees a few flags and three strobes: bit write, resume, and interrupt acknowledge.

Top module: `i2c_bit_assist`

## Requirements
- R1: Both lines pass through a two-flop synchroniser and a 3-sample majority filter. A deviation on either pin that lasts a single clock cycle causes no flag or condition change.
- R2: `bus_busy` is set when filtered SDA falls while filtered SCL is high (START). It is cleared when filtered SDA rises while filtered SCL is high (STOP).
- R3: `irq` stays 0 at START. It becomes 1 on the first filtered SCL falling edge after a START. It stays 1 until an `irq_ack` pulse.
- R4: On each filtered SCL rising edge, `clk_high_seen` becomes 1 and `bit_rx` takes the filtered SDA level.
- R5: On each filtered SCL falling edge, `rd_done` becomes 1. While the bus is busy, the block then pulls SCL low (`scl_pull` = 1) to stretch the low period.
- R6: On an SCL falling edge, `wr_done` becomes 1 unless arbitration was lost on that bit. Loss means the transmit bit was 1 while SDA was sampled 0 at the preceding rising edge. `wr_done` is never 1 while `rd_done` is 0.
- R7: A `resume` pulse releases the SCL stretch and clears `clk_high_seen`, `rd_done` and `wr_done`.
- R8: The transmit bit resets to 1. `sda_pull` is 1 exactly when the transmit bit is 0, so a 0 pulls SDA low and a 1 releases it.
- R9: In master mode, a `bit_wr` pulse acts as a resume. It then pulls SCL low for LOW_CYC cycles and releases it. Once filtered SCL reads high, it keeps SCL released for HIGH_CYC cycles, then stretches SCL low again. The result is exactly one rising edge on SCL.
- R10: With `master_mode` = 0, a `bit_wr` pulse only updates the transmit bit and does not pull SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Level read back from the SCL line |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_pull | output | 1 | 1 = pull SCL low |
| sda_pull | output | 1 | 1 = pull SDA low |
| master_mode | input | 1 | 1 = a bit write generates a clock pulse |
| bit_wr | input | 1 | Write strobe for the one-bit transmit register |
| bit_wdata | input | 1 | Value written to the transmit register |
| resume | input | 1 | Release SCL and clear the per-bit flags |
| irq_ack | input | 1 | Clear the START interrupt |
| bit_rx | output | 1 | Last sampled SDA bit |
| clk_high_seen | output | 1 | SCL rising edge seen since last resume |
| rd_done | output | 1 | SCL pulse completed |
| wr_done | output | 1 | Bit sent with no arbitration loss |
| bus_busy | output | 1 | Bus between START and STOP |
| irq | output | 1 | START interrupt request |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Interrupt timing at START.** A design that raised the interrupt at START itself would show `irq` high before the bench drives the first clock fall.
- **Arbitration loss.** Bits where another driver pulls SDA low against a transmitted 1, in both slave and master mode, must leave `wr_done` low while `rd_done` goes high. A design that skipped the check would report a clean write.
- **Single-cycle glitches.** One-cycle glitches on SCL, and on SDA while SCL is high, must not set `clk_high_seen` or `bus_busy`. An unfiltered design would set a flag or see a false START.
- **Automatic clock.** The bench counts SCL rising edges and expects exactly one. A generator that never stopped, or skipped the release, would produce several edges or none.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [1:0] {
        AC_IDLE = 2'd0,
        AC_LOW  = 2'd1,
        AC_WAIT = 2'd2,
        AC_HIGH = 2'd3
    } ac_state_e;

    typedef struct packed {
        logic busy;
        logic pend;
        logic irq;
        logic clh;
        logic rbf;
        logic wbf;
        logic lost;
        logic rx;
        logic tx;
        logic stretch;
    } core_state_t;

    localparam core_state_t CORE_RST = '{
        busy: 1'b0, pend: 1'b0, irq: 1'b0, clh: 1'b0, rbf: 1'b0,
        wbf: 1'b0, lost: 1'b0, rx: 1'b0, tx: 1'b1, stretch: 1'b0
    };

endpackage

// File: rtl/i2cb_line_filter.sv
module i2cb_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic filt_o
);
    localparam int WIN = 3;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic [WIN-1:0]         win_d, win_q;
    logic                   filt_d, filt_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
        win_d  = {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
        filt_d = (win_q[0] & win_q[1]) | (win_q[1] & win_q[2]) | (win_q[0] & win_q[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            win_q  <= win_d;
            filt_q <= filt_d;
        end
    end

    assign filt_o = filt_q;

    // R1
    filt_needs_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(win_q[0]) == filt_q));

endmodule

// File: rtl/i2cb_bus_events.sv
module i2cb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_prev_d, scl_prev_q;
    logic sda_prev_d, sda_prev_q;

    always_comb begin
        scl_prev_d = scl_f;
        sda_prev_d = sda_f;
        scl_rise   = scl_f & ~scl_prev_q;
        scl_fall   = ~scl_f & scl_prev_q;
        start_ev   = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
        stop_ev    = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

endmodule

// File: rtl/i2cb_auto_clock.sv
module i2cb_auto_clock
    import i2cb_pkg::*;
#(
    parameter int LOW_CYC  = 8,
    parameter int HIGH_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic scl_f,
    output logic drive_low,
    output logic done
);
    localparam int MAXC  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CYC - 1);

    ac_state_e        st_d, st_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        done  = 1'b0;
        unique case (st_q)
            AC_IDLE: if (go) begin
                st_d  = AC_LOW;
                cnt_d = '0;
            end
            AC_LOW: begin
                if (cnt_q == LOW_LAST) begin
                    st_d  = AC_WAIT;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            AC_WAIT: if (scl_f) begin
                st_d  = AC_HIGH;
                cnt_d = '0;
            end
            AC_HIGH: begin
                if (cnt_q == HIGH_LAST) begin
                    st_d = AC_IDLE;
                    done = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = AC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= AC_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign drive_low = (st_q == AC_LOW);

    // R9
    low_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> $past(go));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AC_LOW) |-> (cnt_q <= LOW_LAST));

endmodule

// File: rtl/i2c_bit_assist.sv
module i2c_bit_assist
    import i2cb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_CYC     = 8,
    parameter int HIGH_CYC    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_pull,
    output logic sda_pull,
    input  logic master_mode,
    input  logic bit_wr,
    input  logic bit_wdata,
    input  logic resume,
    input  logic irq_ack,
    output logic bit_rx,
    output logic clk_high_seen,
    output logic rd_done,
    output logic wr_done,
    output logic bus_busy,
    output logic irq
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] pins, filt;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic ac_go, ac_low, ac_done;

    core_state_t d, q;

    assign pins = {sda_in, scl_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_filt
        i2cb_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pins[i]),
            .filt_o(filt[i])
        );
    end

    assign scl_f = filt[0];
    assign sda_f = filt[1];

    i2cb_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    assign ac_go = bit_wr & master_mode;

    i2cb_auto_clock #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_autoclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (ac_go),
        .scl_f    (scl_f),
        .drive_low(ac_low),
        .done     (ac_done)
    );

    always_comb begin
        d = q;
        if (resume || ac_go) begin
            d.stretch = 1'b0;
            d.clh     = 1'b0;
            d.rbf     = 1'b0;
            d.wbf     = 1'b0;
            d.lost    = 1'b0;
        end
        if (bit_wr)  d.tx  = bit_wdata;
        if (irq_ack) d.irq = 1'b0;
        if (start_ev) begin
            d.busy = 1'b1;
            d.pend = 1'b1;
        end
        if (stop_ev) begin
            d.busy = 1'b0;
            d.pend = 1'b0;
        end
        if (scl_rise) begin
            d.clh  = 1'b1;
            d.rx   = sda_f;
            d.lost = q.tx & ~sda_f;
        end
        if (scl_fall) begin
            d.rbf = 1'b1;
            d.wbf = ~q.lost;
            if (q.busy) d.stretch = 1'b1;
            if (q.pend) begin
                d.irq  = 1'b1;
                d.pend = 1'b0;
            end
        end
        if (ac_done) d.stretch = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CORE_RST;
        else        q <= d;
    end

    assign scl_pull      = q.stretch | ac_low;
    assign sda_pull      = ~q.tx;
    assign bit_rx        = q.rx;
    assign clk_high_seen = q.clh;
    assign rd_done       = q.rbf;
    assign wr_done       = q.wbf;
    assign bus_busy      = q.busy;
    assign irq           = q.irq;

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(start_ev));

    // R3
    irq_from_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> $past(scl_fall));

    // R6
    wbf_implies_rbf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wbf |-> q.rbf);

    // R7
    resume_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && !scl_fall && !ac_done) |=> !q.stretch);

endmodule

// File: tb/i2c_bit_assist_tb_top.sv
`timescale 1ns/1ps
module i2c_bit_assist_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_mode = 1'b0, bit_wr = 1'b0, bit_wdata = 1'b0;
    logic resume = 1'b0, irq_ack = 1'b0;
    logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
    logic scl_line, sda_line, scl_pull, sda_pull;
    logic bit_rx, clk_high_seen, rd_done, wr_done, bus_busy, irq;
    int   n_checks = 0, n_fail = 0, scl_rises = 0;

    always #4 clk = ~clk;

    assign scl_line = ~(scl_pull | tb_scl_low);
    assign sda_line = ~(sda_pull | tb_sda_low);

    always @(posedge scl_line) scl_rises++;

    i2c_bit_assist dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .master_mode(master_mode),
        .bit_wr(bit_wr), .bit_wdata(bit_wdata), .resume(resume), .irq_ack(irq_ack),
        .bit_rx(bit_rx), .clk_high_seen(clk_high_seen), .rd_done(rd_done),
        .wr_done(wr_done), .bus_busy(bus_busy), .irq(irq)
    );

    // {tx bit, other driver pulls SDA low, expected bit_rx, expected wr_done}
    localparam logic [3:0] VEC [6] = '{4'b1011, 4'b0001, 4'b1100,
                                       4'b0101, 4'b1011, 4'b0001};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic v);
        bit_wdata = v; bit_wr = 1'b1; step(1); bit_wr = 1'b0;
    endtask

    task automatic do_resume();
        resume = 1'b1; step(1); resume = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // reset state
        chk("R2 reset busy", bus_busy, 1'b0);
        chk("R3 reset irq", irq, 1'b0);
        chk("R5 reset scl_pull", scl_pull, 1'b0);
        chk("R8 reset sda_pull", sda_pull, 1'b0);
        chk("R6 reset wr_done", wr_done, 1'b0);

        // START: SDA falls with SCL high
        tb_sda_low = 1'b1; step(10);
        chk("R2 busy after START", bus_busy, 1'b1);
        chk("R3 no irq at START", irq, 1'b0);
        tb_scl_low = 1'b1; step(10);
        chk("R3 irq after first fall", irq, 1'b1);
        chk("R5 stretch after first fall", scl_pull, 1'b1);
        do_ack(); step(1);
        chk("R3 irq cleared by ack", irq, 1'b0);

        // slave-mode bit transfers from the vector table
        foreach (VEC[k]) begin
            do_write(VEC[k][3]);
            tb_sda_low = VEC[k][2];
            do_resume(); step(8);
            chk("R8 sda_pull follows tx", sda_pull, ~VEC[k][3]);
            chk("R7 resume releases SCL", scl_pull, 1'b0);
            chk("R7 resume clears rd_done", rd_done, 1'b0);
            chk("R7 resume clears clh", clk_high_seen, 1'b0);
            tb_scl_low = 1'b0; step(10);
            chk("R4 clh on rise", clk_high_seen, 1'b1);
            chk("R4 bit_rx sampled", bit_rx, VEC[k][1]);
            tb_scl_low = 1'b1; step(10);
            chk("R5 rd_done on fall", rd_done, 1'b1);
            chk("R6 wr_done arbitration", wr_done, VEC[k][0]);
            chk("R5 stretch on fall", scl_pull, 1'b1);
        end

        // STOP: SDA rises with SCL high
        tb_sda_low = 1'b1;
        do_write(1'b1);
        do_resume();
        tb_scl_low = 1'b0; step(10);
        chk("R2 still busy before STOP", bus_busy, 1'b1);
        tb_sda_low = 1'b0; step(10);
        chk("R2 busy cleared by STOP", bus_busy, 1'b0);

        // single-cycle glitches on an idle bus
        do_resume(); step(4);
        tb_scl_low = 1'b1; step(1); tb_scl_low = 1'b0; step(10);
        chk("R1 SCL glitch no clh", clk_high_seen, 1'b0);
        chk("R1 SCL glitch no rd_done", rd_done, 1'b0);
        tb_sda_low = 1'b1; step(1); tb_sda_low = 1'b0; step(10);
        chk("R1 SDA glitch no START", bus_busy, 1'b0);

        // slave-mode write does not clock
        do_write(1'b1); step(2);
        chk("R10 slave write no SCL pull", scl_pull, 1'b0);
        step(10);
        chk("R10 slave write no clh", clk_high_seen, 1'b0);

        // master mode: START, then an automatic clock
        master_mode = 1'b1;
        tb_sda_low = 1'b1; step(10);
        tb_scl_low = 1'b1; step(10);
        do_ack();
        tb_scl_low = 1'b0; tb_sda_low = 1'b0; step(4);
        chk("R5 master stretch holds SCL", scl_pull, 1'b1);
        scl_rises = 0;
        do_write(1'b1); step(2);
        chk("R9 low phase drives SCL", scl_pull, 1'b1);
        chk("R9 write clears rd_done", rd_done, 1'b0);
        step(50);
        chk("R9 exactly one SCL rise", scl_rises == 1, 1'b1);
        chk("R9 clh after pulse", clk_high_seen, 1'b1);
        chk("R9 rd_done after pulse", rd_done, 1'b1);
        chk("R9 wr_done after pulse", wr_done, 1'b1);
        chk("R9 bit_rx after pulse", bit_rx, 1'b1);
        chk("R9 stretch after pulse", scl_pull, 1'b1);

        // master mode: arbitration loss
        tb_sda_low = 1'b1;
        scl_rises = 0;
        do_write(1'b1); step(50);
        chk("R9 one rise on second pulse", scl_rises == 1, 1'b1);
        chk("R6 master loss rd_done", rd_done, 1'b1);
        chk("R6 master loss wr_done low", wr_done, 1'b0);
        chk("R4 master loss bit_rx", bit_rx, 1'b0);

        // release and STOP
        master_mode = 1'b0;
        do_resume(); step(10);
        tb_sda_low = 1'b0; step(10);
        chk("R2 STOP after master", bus_busy, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule